// File: doc/BRIEF.md
# External Bus Strobe Timing Generator

This block times single accesses to one chip-select region of an external parallel bus. A request port takes an access, which is a read or a write with an address and write data. The block then drives the chip select and the address for a one-clock address phase. After that it drives the read or write strobe for a data phase. The data phase length comes from a wait-state code, and reads and writes each have their own code. A done pulse ends the access, and read data captured from the bus is held on `rdata_o` until the next read completes.

The read strobe can be made active-high for the region, but only when the dual-select configuration input is set. The write strobe, and the read strobe in every other case, is active-low. The wait-state code and the polarity choice are latched when an access is accepted. Changes on those inputs during an access do not affect it.

Top module: `ext_strobe_gen`

## Requirements
- R1: After reset `ready_o` is 1. `cs_n_o` and `wr_n_o` are 1, `rd_o` is 1 (inactive low), and `data_oe_o` and `done_o` are 0.
- R2: A request (`req_valid_i`=1) is accepted only on a clock edge where `ready_o` is 1. A request presented while the block is busy has no effect on the access in progress.
- R3: The clock after acceptance is the address phase. It lasts exactly one clock, with `cs_n_o`=0, `addr_o` equal to the request address, and both strobes inactive. `addr_o` is held for the whole access.
- R4: A write holds `wr_n_o` at 0 for 2*(code+1) clocks, where the code is the 2-bit `wr_ws_i` field. Codes 0, 1, 2 and 3 give 2, 4, 6 and 8 clocks, and the address phase length does not change.
- R5: A read holds the read strobe active for 2*(code+1) clocks, where the code is the 2-bit `rd_ws_i` field. It starts right after the one-clock address phase.
- R6: The read strobe's active level is high when `dual_cs_en_i`=1 and `rd_pol_i`=1, and low in every other case. Its inactive level is the inverse, and that level is held until the next accepted access.
- R7: `data_oe_o` is 1 exactly during the clocks where a write holds `wr_n_o` low. It is 0 during reads and when idle. `wdata_o` carries the request's write data while it is 1.
- R8: Read data is sampled from `bus_rdata_i` at the clock edge that ends the last active read strobe clock. It appears on `rdata_o` from the done clock on and is unchanged by writes.
- R9: `done_o` is 1 for exactly one clock, the clock right after the strobe deasserts. In that clock `cs_n_o` is 1, and `ready_o` returns to 1 on the next clock.
- R10: The wait-state codes, `rd_pol_i` and `dual_cs_en_i` are latched at acceptance. Changing them during an access does not change its timing or polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW | Access address |
| req_wdata_i | input | DW | Write data |
| rd_ws_i | input | WS_W | Read wait-state code |
| wr_ws_i | input | WS_W | Write wait-state code |
| rd_pol_i | input | 1 | Read strobe active-high select |
| dual_cs_en_i | input | 1 | Enables the read polarity select |
| bus_rdata_i | input | DW | Data bus input |
| ready_o | output | 1 | Idle, accepting a request |
| cs_n_o | output | 1 | Chip select, active low |
| addr_o | output | AW | Address bus |
| wdata_o | output | DW | Data bus output value |
| data_oe_o | output | 1 | Data bus output enable |
| rd_o | output | 1 | Read strobe, polarity per R6 |
| wr_n_o | output | 1 | Write strobe, active low |
| rdata_o | output | DW | Captured read data |
| done_o | output | 1 | Access complete pulse |

## Verification
The assertions assume that reset is held long enough to clear the sequencer. They also assume that `req_valid_i`, the settings and `bus_rdata_i` change only away from the active clock edge, so each edge sees settled values. The stimulus drives every input just after the falling edge. It presents requests while the block is busy, changes the wait-state and polarity inputs in the middle of accesses, and changes `bus_rdata_i` every clock, so that the sampling edge can be identified.

// File: rtl/ext_strobe_pkg.sv
package ext_strobe_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2,
    PH_DONE = 2'd3
  } phase_e;
endpackage

// File: rtl/access_latch.sv
module access_latch #(
  parameter int AW   = 16,
  parameter int DW   = 16,
  parameter int WS_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic            write_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [WS_W-1:0] rd_ws_i,
  input  logic [WS_W-1:0] wr_ws_i,
  input  logic            rd_pol_i,
  input  logic            dual_cs_en_i,
  output logic            write_o,
  output logic [AW-1:0]   addr_o,
  output logic [DW-1:0]   wdata_o,
  output logic            rd_high_o,
  output logic [WS_W-1:0] ws_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      write_o   <= 1'b0;
      addr_o    <= '0;
      wdata_o   <= '0;
      rd_high_o <= 1'b0;
      ws_o      <= '0;
    end else if (load_i) begin
      write_o   <= write_i;
      addr_o    <= addr_i;
      wdata_o   <= wdata_i;
      // polarity select only honoured in dual-select configuration
      rd_high_o <= dual_cs_en_i & rd_pol_i;
      ws_o      <= write_i ? wr_ws_i : rd_ws_i;
    end
  end
endmodule

// File: rtl/strobe_seq.sv
module strobe_seq
  import ext_strobe_pkg::*;
#(
  parameter int WS_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [WS_W-1:0] ws_i,
  output phase_e          phase_o,
  output logic            last_o
);
  localparam int CNT_W = WS_W + 1;

  phase_e             phase_q, phase_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [CNT_W-1:0]   len_m1;

  // active clocks = 2*(ws+1); preload with that minus one
  assign len_m1 = {ws_i, 1'b1};

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    unique case (phase_q)
      PH_IDLE: if (start_i) phase_d = PH_ADDR;
      PH_ADDR: begin
        phase_d = PH_DATA;
        cnt_d   = len_m1;
      end
      PH_DATA: begin
        if (cnt_q == '0) phase_d = PH_DONE;
        else             cnt_d   = cnt_q - 1'b1;
      end
      PH_DONE: phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign phase_o = phase_q;
  assign last_o  = (phase_q == PH_DATA) && (cnt_q == '0);
endmodule

// File: rtl/rdata_capture.sv
module rdata_capture #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sample_i,
  input  logic [DW-1:0] bus_i,
  output logic [DW-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       data_o <= '0;
    else if (sample_i) data_o <= bus_i;
  end
endmodule

// File: rtl/ext_strobe_gen.sv
module ext_strobe_gen
  import ext_strobe_pkg::*;
#(
  parameter int AW   = 16,
  parameter int DW   = 16,
  parameter int WS_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  input  logic            req_write_i,
  input  logic [AW-1:0]   req_addr_i,
  input  logic [DW-1:0]   req_wdata_i,
  input  logic [WS_W-1:0] rd_ws_i,
  input  logic [WS_W-1:0] wr_ws_i,
  input  logic            rd_pol_i,
  input  logic            dual_cs_en_i,
  input  logic [DW-1:0]   bus_rdata_i,
  output logic            ready_o,
  output logic            cs_n_o,
  output logic [AW-1:0]   addr_o,
  output logic [DW-1:0]   wdata_o,
  output logic            data_oe_o,
  output logic            rd_o,
  output logic            wr_n_o,
  output logic [DW-1:0]   rdata_o,
  output logic            done_o
);
  phase_e          phase;
  logic            last;
  logic            start;
  logic            lat_write;
  logic            lat_rd_high;
  logic [WS_W-1:0] lat_ws;
  logic            in_data;

  assign start = req_valid_i && (phase == PH_IDLE);

  access_latch #(.AW(AW), .DW(DW), .WS_W(WS_W)) i_latch (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (start),
    .write_i      (req_write_i),
    .addr_i       (req_addr_i),
    .wdata_i      (req_wdata_i),
    .rd_ws_i      (rd_ws_i),
    .wr_ws_i      (wr_ws_i),
    .rd_pol_i     (rd_pol_i),
    .dual_cs_en_i (dual_cs_en_i),
    .write_o      (lat_write),
    .addr_o       (addr_o),
    .wdata_o      (wdata_o),
    .rd_high_o    (lat_rd_high),
    .ws_o         (lat_ws)
  );

  strobe_seq #(.WS_W(WS_W)) i_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .ws_i    (lat_ws),
    .phase_o (phase),
    .last_o  (last)
  );

  rdata_capture #(.DW(DW)) i_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sample_i (last && !lat_write),
    .bus_i    (bus_rdata_i),
    .data_o   (rdata_o)
  );

  assign in_data   = (phase == PH_DATA);
  assign ready_o   = (phase == PH_IDLE);
  assign cs_n_o    = !((phase == PH_ADDR) || in_data);
  assign wr_n_o    = !(in_data && lat_write);
  assign data_oe_o = in_data && lat_write;
  assign rd_o      = (in_data && !lat_write) ? lat_rd_high : !lat_rd_high;
  assign done_o    = (phase == PH_DONE);
endmodule

// File: rtl/ext_strobe_gen_chk.sv
module ext_strobe_gen_chk #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ready_o,
  input logic          cs_n_o,
  input logic [AW-1:0] addr_o,
  input logic          data_oe_o,
  input logic          rd_o,
  input logic          wr_n_o,
  input logic [DW-1:0] rdata_o,
  input logic          done_o,
  input logic          rd_high
);
  logic rd_act;
  assign rd_act = (rd_o == rd_high);

  assert_idle_no_cs_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> cs_n_o && wr_n_o && !rd_act && !done_o);

  assert_addr_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_o && $past(!cs_n_o)) |-> $stable(addr_o));

  assert_strobes_exclusive_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_act && !wr_n_o));

  assert_strobe_needs_cs_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_act || !wr_n_o) |-> !cs_n_o);

  assert_oe_with_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> !wr_n_o);

  assert_rdata_only_at_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rdata_o) |-> done_o);

  assert_done_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && ready_o);

  assert_done_after_strobe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cs_n_o && $past(!cs_n_o));
endmodule

bind ext_strobe_gen ext_strobe_gen_chk #(.AW(AW), .DW(DW)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ready_o   (ready_o),
  .cs_n_o    (cs_n_o),
  .addr_o    (addr_o),
  .data_oe_o (data_oe_o),
  .rd_o      (rd_o),
  .wr_n_o    (wr_n_o),
  .rdata_o   (rdata_o),
  .done_o    (done_o),
  .rd_high   (lat_rd_high)
);

// File: tb/test_ext_strobe_gen.sv
module test_ext_strobe_gen;
  localparam int AW = 16;
  localparam int DW = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid_i = 1'b0;
  logic          req_write_i = 1'b0;
  logic [AW-1:0] req_addr_i = '0;
  logic [DW-1:0] req_wdata_i = '0;
  logic [1:0]    rd_ws_i = '0;
  logic [1:0]    wr_ws_i = '0;
  logic          rd_pol_i = 1'b0;
  logic          dual_cs_en_i = 1'b0;
  logic [DW-1:0] bus_rdata_i = '0;
  logic          ready_o, cs_n_o, data_oe_o, rd_o, wr_n_o, done_o;
  logic [AW-1:0] addr_o;
  logic [DW-1:0] wdata_o, rdata_o;

  ext_strobe_gen #(.AW(AW), .DW(DW), .WS_W(2)) i_ext_strobe_gen (.*);

  always #4 clk_i = ~clk_i;

  int n_vec = 0;
  int n_err = 0;

  // behavioural reference
  bit      m_busy = 0;
  int      m_t = 0;
  int      m_n = 2;
  bit      m_wr = 0;
  bit      m_high = 0;
  int      m_addr = 0;
  int      m_wdata = 0;
  int      m_rdata = 0;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_busy = 0; m_t = 0; m_n = 2; m_wr = 0; m_high = 0;
      m_addr = 0; m_wdata = 0; m_rdata = 0;
    end else if (!m_busy) begin
      if (req_valid_i) begin
        m_busy  = 1; m_t = 0;
        m_wr    = req_write_i;
        m_n     = 2 * ((req_write_i ? int'(wr_ws_i) : int'(rd_ws_i)) + 1);
        m_high  = dual_cs_en_i && rd_pol_i;
        m_addr  = int'(req_addr_i);
        m_wdata = int'(req_wdata_i);
      end
    end else begin
      if (m_t == m_n && !m_wr) m_rdata = int'(bus_rdata_i);
      if (m_t == m_n + 1) m_busy = 0;
      else m_t++;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni) begin
      bit cs_a, dat, rdact;
      cs_a  = m_busy && m_t <= m_n;
      dat   = m_busy && m_t >= 1 && m_t <= m_n;
      rdact = dat && !m_wr;
      chk("R1/R2 ready", int'(ready_o), int'(!m_busy));
      chk("R3 cs_n", int'(cs_n_o), int'(!cs_a));
      chk("R4 wr_n", int'(wr_n_o), int'(!(dat && m_wr)));
      chk("R5/R6 rd", int'(rd_o), int'(rdact ? m_high : !m_high));
      chk("R7 data_oe", int'(data_oe_o), int'(dat && m_wr));
      chk("R9 done", int'(done_o), int'(m_busy && m_t == m_n + 1));
      chk("R8 rdata", int'(rdata_o), m_rdata);
      if (cs_a) chk("R3 addr", int'(addr_o), m_addr);
      if (dat && m_wr) chk("R7 wdata", int'(wdata_o), m_wdata);
    end
  end

  // data bus changes every clock so the sampling edge is visible
  always @(negedge clk_i) #1 bus_rdata_i <= bus_rdata_i + 16'h0101;

  task automatic access(bit wr, logic [AW-1:0] a, logic [DW-1:0] d, bit scramble, bit hold_req);
    @(negedge clk_i); #1;
    req_valid_i = 1; req_write_i = wr; req_addr_i = a; req_wdata_i = d;
    @(negedge clk_i); #1;
    if (!hold_req) req_valid_i = 0;
    else begin req_addr_i = ~a; req_write_i = !wr; end  // R2: busy request ignored
    if (scramble) begin  // R10: settings change mid-access
      rd_ws_i = ~rd_ws_i; wr_ws_i = ~wr_ws_i;
      rd_pol_i = !rd_pol_i; dual_cs_en_i = !dual_cs_en_i;
    end
    while (!ready_o) begin @(negedge clk_i); #1; end
    req_valid_i = 0;
    repeat (2) @(negedge clk_i);
  endtask

  initial begin
    fork
      begin
        #1;
        chk("R1 reset ready", int'(ready_o), 1);
        chk("R1 reset cs_n", int'(cs_n_o), 1);
        chk("R1 reset rd", int'(rd_o), 1);
        chk("R1 reset wr_n", int'(wr_n_o), 1);
        chk("R1 reset oe", int'(data_oe_o), 0);
        chk("R1 reset done", int'(done_o), 0);
        repeat (3) @(negedge clk_i);
        rst_ni = 1;
        for (int w = 0; w < 4; w++) begin
          wr_ws_i = 2'(w); rd_ws_i = 2'(3 - w);
          access(1'b1, 16'h1000 + 16'(w), 16'hA500 + 16'(w), 1'b0, 1'b0);
          access(1'b0, 16'h2000 + 16'(w), 16'h0, 1'b0, 1'b0);
        end
        for (int p = 0; p < 4; p++) begin
          dual_cs_en_i = p[1]; rd_pol_i = p[0]; rd_ws_i = 2'(p);
          access(1'b0, 16'h3000 + 16'(p), 16'h0, 1'b0, 1'b0);
          access(1'b1, 16'h3100 + 16'(p), 16'h5A00 + 16'(p), 1'b0, 1'b0);
        end
        dual_cs_en_i = 1; rd_pol_i = 1; rd_ws_i = 2'd1; wr_ws_i = 2'd2;
        access(1'b0, 16'h4000, 16'h0, 1'b1, 1'b0);
        access(1'b1, 16'h4001, 16'h1234, 1'b1, 1'b0);
        access(1'b0, 16'h4002, 16'h0, 1'b0, 1'b1);
        access(1'b1, 16'h4003, 16'hBEEF, 1'b0, 1'b1);
        repeat (4) @(negedge clk_i);
      end
      begin
        repeat (20000) @(posedge clk_i);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule